// File: doc/BRIEF.md
# Sequenced Watchdog Reset Generator

This block produces a reset pulse of fixed length and a set of cause flags that a host can read. It has two reset sources, and a select input chooses between them. The first is a watchdog timer. A prescaler divides the system clock into ticks, and the timer expires after a parameterised number of ticks unless the host services it first. To service the timer, the host writes a two-bit key field twice, in a fixed order. The second source is a wake-up path. A falling edge on an active-low awake input triggers a reset, and so does a one-cycle pulse that reports a change in a command/indication code. A separate terminal-functions enable gates both sources. While that enable is low, the block never issues a reset.

A low level on the awake input also raises a clock-enable request for the serial interface, in every mode. The cause flags are set in the cycle a reset is launched. A status-read strobe clears them. All inputs are assumed to be synchronous to `clk`.

Three state machines make up the design. The key sequencer has two states. `SVC_IDLE` moves to `SVC_ARMED` on a write of the first key. `SVC_ARMED` returns to `SVC_IDLE` on any write: a write of the second key services the timer, and any other write aborts the sequence. The pulse controller also has two states. `PL_IDLE` moves to `PL_ACTIVE` when a trigger is accepted. `PL_ACTIVE` returns to `PL_IDLE` once its length counter has run out. The timer is a pair of counters (prescaler and tick) that wrap to zero on expiry.

Top module: `wdg_reset_gen`

## Requirements
- R1: After reset, `rst_pulse`, `cause_wdg`, `cause_awake` and `cause_code` are all 0.
- R2: With `term_en`=1 and `src_sel`=1 (watchdog mode), and no valid service, `rst_pulse` rises exactly PRESCALE*PERIOD_TICKS cycles after the mode becomes active. `cause_wdg` sets in the same cycle. The timer then restarts from zero.
- R3: In watchdog mode, writing `svc_key`=2'b10 and then, as the next write, `svc_key`=2'b01 clears the timer to zero. Regular servicing therefore prevents any reset.
- R4: A write of any value other than 2'b01 after 2'b10 aborts the sequence and does not service the timer. A 2'b01 write without a preceding 2'b10 does not service it either.
- R5: `rst_pulse` stays high for exactly PULSE_LEN cycles. Triggers that arrive while it is high are ignored, and they set no cause flag.
- R6: In wake-up mode (`term_en`=1, `src_sel`=0), a 1-to-0 transition on `awake_n` launches a reset pulse in the next cycle and sets `cause_awake`.
- R7: In wake-up mode, `code_chg`=1 launches a reset pulse in the next cycle and sets `cause_code`.
- R8: In watchdog mode, `awake_n` edges and `code_chg` are ignored. In wake-up mode, the timer never expires.
- R9: While `term_en`=0, no source launches a reset, and the timer and key sequencer are held cleared.
- R10: `clk_req` equals the inverse of `awake_n` in every mode, including while `term_en`=0.
- R11: `stat_rd`=1 clears all cause flags on the next edge. A flag set by a trigger in the same cycle as the read survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_en | input | 1 | Terminal-functions enable; gates both reset sources |
| src_sel | input | 1 | 1 selects the watchdog, 0 selects the wake-up sources |
| svc_wr | input | 1 | Service register write strobe |
| svc_key | input | KEY_W | Key field of the service write |
| awake_n | input | 1 | External awake line, active low |
| code_chg | input | 1 | One-cycle code-change event |
| stat_rd | input | 1 | Status read strobe; clears cause flags |
| rst_pulse | output | 1 | Generated reset pulse |
| cause_wdg | output | 1 | Last reset came from watchdog expiry |
| cause_awake | output | 1 | Last reset came from an awake falling edge |
| cause_code | output | 1 | Last reset came from a code change |
| clk_req | output | 1 | Request to enable the serial interface clock and frame |

## Verification
The bench builds the block with PRESCALE=4, PERIOD_TICKS=8 and PULSE_LEN=3. With these values the watchdog expires after 32 cycles, so many expiries, services and aborted sequences fit into a few thousand cycles. The short pulse also makes it common for triggers to land while a pulse is active, and for a status read to coincide with a new trigger.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic {SVC_IDLE, SVC_ARMED} svc_state_t;
    typedef enum logic {PL_IDLE, PL_ACTIVE} pl_state_t;
    typedef struct packed {
        logic wdg;
        logic awake;
        logic code;
    } cause_t;
endpackage

// File: rtl/wdg_svc_seq.sv
module wdg_svc_seq
    import wdg_pkg::*;
#(
    parameter int KEY_W = 2,
    parameter logic [KEY_W-1:0] KEY_FIRST = 2'b10,
    parameter logic [KEY_W-1:0] KEY_SECOND = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr,
    input  logic [KEY_W-1:0] wdata,
    output logic             svc_ok
);
    svc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = SVC_IDLE;
        end else if (wr) begin
            unique case (state_q)
                SVC_IDLE:  state_d = (wdata == KEY_FIRST) ? SVC_ARMED : SVC_IDLE;
                SVC_ARMED: state_d = SVC_IDLE;
            endcase
        end
    end

    always_comb begin
        svc_ok = 1'b0;
        unique case (state_q)
            SVC_IDLE:  svc_ok = 1'b0;
            SVC_ARMED: svc_ok = enable && wr && (wdata == KEY_SECOND);
        endcase
    end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
    parameter int PRESCALE = 4,
    parameter int PERIOD_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    output logic expire
);
    localparam int DIV_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int TICK_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(PRESCALE - 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(PERIOD_TICKS - 1);

    logic [DIV_W-1:0]  div_q;
    logic [TICK_W-1:0] tick_q;
    logic              div_wrap;

    assign div_wrap = (div_q == DIV_LAST);
    assign expire   = enable && !restart && div_wrap && (tick_q == TICK_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_q <= '0;
        end else if (!enable || restart) begin
            div_q  <= '0;
            tick_q <= '0;
        end else if (div_wrap) begin
            div_q  <= '0;
            tick_q <= (tick_q == TICK_LAST) ? '0 : tick_q + 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_pulse_fsm.sv
module wdg_pulse_fsm
    import wdg_pkg::*;
#(
    parameter int PULSE_LEN = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t events,
    input  logic   stat_rd,
    output logic   pulse,
    output cause_t cause
);
    localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_LEN - 1);

    pl_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    cause_t           set_mask;

    assign accept   = (state_q == PL_IDLE) && (|events);
    assign set_mask = accept ? events : cause_t'('0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PL_IDLE:   if (accept) state_d = PL_ACTIVE;
            PL_ACTIVE: if (cnt_q == CNT_LAST) state_d = PL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (state_q == PL_ACTIVE)  cnt_q <= cnt_q + 1'b1;
        else                            cnt_q <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause <= '0;
        else        cause <= (stat_rd ? cause_t'('0) : cause) | set_mask;
    end

    always_comb begin
        pulse = 1'b0;
        unique case (state_q)
            PL_IDLE:   pulse = 1'b0;
            PL_ACTIVE: pulse = 1'b1;
        endcase
    end
endmodule

// File: rtl/wdg_reset_gen.sv
module wdg_reset_gen
    import wdg_pkg::*;
#(
    parameter int PRESCALE = 65536,
    parameter int PERIOD_TICKS = 128,
    parameter int PULSE_LEN = 16,
    parameter int KEY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             term_en,
    input  logic             src_sel,
    input  logic             svc_wr,
    input  logic [KEY_W-1:0] svc_key,
    input  logic             awake_n,
    input  logic             code_chg,
    input  logic             stat_rd,
    output logic             rst_pulse,
    output logic             cause_wdg,
    output logic             cause_awake,
    output logic             cause_code,
    output logic             clk_req
);
    logic   wdg_mode, wake_mode;
    logic   svc_ok, expire;
    logic   awake_prev_q;
    cause_t events, cause;

    assign wdg_mode  = term_en && src_sel;
    assign wake_mode = term_en && !src_sel;

    wdg_svc_seq #(
        .KEY_W(KEY_W),
        .KEY_FIRST(KEY_W'(2'b10)),
        .KEY_SECOND(KEY_W'(2'b01))
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(wdg_mode),
        .wr(svc_wr), .wdata(svc_key), .svc_ok(svc_ok)
    );

    wdg_timer #(.PRESCALE(PRESCALE), .PERIOD_TICKS(PERIOD_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .enable(wdg_mode),
        .restart(svc_ok), .expire(expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) awake_prev_q <= 1'b1;
        else        awake_prev_q <= awake_n;
    end

    assign events.wdg   = expire;
    assign events.awake = wake_mode && awake_prev_q && !awake_n;
    assign events.code  = wake_mode && code_chg;

    wdg_pulse_fsm #(.PULSE_LEN(PULSE_LEN)) u_pls (
        .clk(clk), .rst_n(rst_n), .events(events), .stat_rd(stat_rd),
        .pulse(rst_pulse), .cause(cause)
    );

    assign cause_wdg   = cause.wdg;
    assign cause_awake = cause.awake;
    assign cause_code  = cause.code;
    assign clk_req     = !awake_n;
endmodule

// File: rtl/wdg_reset_gen_chk.sv
module wdg_reset_gen_chk #(
    parameter int PULSE_LEN = 16
) (
    input logic clk,
    input logic rst_n,
    input logic term_en,
    input logic src_sel,
    input logic code_chg,
    input logic stat_rd,
    input logic rst_pulse,
    input logic cause_wdg,
    input logic cause_awake,
    input logic cause_code
);
    localparam int HW = $clog2(PULSE_LEN + 1) + 1;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_cnt <= '0;
        else if (rst_pulse) hi_cnt <= hi_cnt + 1'b1;
        else                hi_cnt <= '0;
    end

    assert_pulse_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> (hi_cnt < HW'(PULSE_LEN)));
    assert_pulse_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pulse) |-> (hi_cnt == HW'(PULSE_LEN)));
    assert_cause_on_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> (cause_wdg || cause_awake || cause_code));
    assert_enable_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> $past(term_en));
    assert_wdg_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_wdg) |-> $past(src_sel));
    assert_awake_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_awake) |-> $past(!src_sel));
    assert_code_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_code) |-> $past(!src_sel && code_chg));
    assert_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && rst_pulse) |=> !(cause_wdg || cause_awake || cause_code));
endmodule

bind wdg_reset_gen wdg_reset_gen_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .term_en(term_en), .src_sel(src_sel),
    .code_chg(code_chg), .stat_rd(stat_rd), .rst_pulse(rst_pulse),
    .cause_wdg(cause_wdg), .cause_awake(cause_awake), .cause_code(cause_code)
);

// File: tb/sim_wdg_reset_gen.sv
`timescale 1ns/1ps
module sim_wdg_reset_gen;
    localparam int P = 4, T = 8, L = 3;
    localparam int LIMIT = 200000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic term_en = 0, src_sel = 0, svc_wr = 0, awake_n = 1, code_chg = 0, stat_rd = 0;
    logic [1:0] svc_key = 2'b00;
    logic rst_pulse, cause_wdg, cause_awake, cause_code, clk_req;

    int errors = 0, checks = 0, cycles = 0;
    string cur_req = "R1";
    bit pulse_seen;

    // reference model state
    int m_div, m_tick, m_seq, m_prev, m_pst, m_pcnt, m_cw, m_ca, m_cc;

    always #10 clk = ~clk;

    wdg_reset_gen #(.PRESCALE(P), .PERIOD_TICKS(T), .PULSE_LEN(L), .KEY_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .term_en(term_en), .src_sel(src_sel),
        .svc_wr(svc_wr), .svc_key(svc_key), .awake_n(awake_n), .code_chg(code_chg),
        .stat_rd(stat_rd), .rst_pulse(rst_pulse), .cause_wdg(cause_wdg),
        .cause_awake(cause_awake), .cause_code(cause_code), .clk_req(clk_req)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_div = 0; m_tick = 0; m_seq = 0; m_prev = 1;
        m_pst = 0; m_pcnt = 0; m_cw = 0; m_ca = 0; m_cc = 0;
    endtask

    function automatic bit at_expiry(int d, int t);
        return (d == P - 1) && (t == T - 1);
    endfunction

    task automatic model_next();
        bit wd, wk, ok, ex, fa, cc, trig;
        wd = term_en && src_sel;
        wk = term_en && !src_sel;
        ok = wd && (m_seq == 1) && svc_wr && (svc_key == 2'b01);
        ex = wd && !ok && at_expiry(m_div, m_tick);
        fa = wk && (m_prev == 1) && !awake_n;
        cc = wk && code_chg;
        trig = (m_pst == 0) && (ex || fa || cc);
        if (!wd) m_seq = 0;
        else if (svc_wr) m_seq = (m_seq == 0 && svc_key == 2'b10) ? 1 : 0;
        if (!wd || ok) begin m_div = 0; m_tick = 0; end
        else if (m_div == P - 1) begin
            m_div = 0; m_tick = (m_tick == T - 1) ? 0 : m_tick + 1;
        end else m_div++;
        m_prev = awake_n;
        if (stat_rd) begin m_cw = 0; m_ca = 0; m_cc = 0; end
        if (trig) begin
            if (ex) m_cw = 1;
            if (fa) m_ca = 1;
            if (cc) m_cc = 1;
        end
        if (m_pst == 0) begin
            if (trig) begin m_pst = 1; m_pcnt = 0; end
        end else if (m_pcnt == L - 1) m_pst = 0;
        else m_pcnt++;
    endtask

    // one clock: inputs already applied after a negedge
    task automatic cyc();
        #1;
        chk(clk_req == !awake_n, "R10", "clk_req", clk_req, !awake_n);
        model_next();
        @(posedge clk);
        @(negedge clk);
        chk(rst_pulse == m_pst, cur_req, "rst_pulse", rst_pulse, m_pst);
        chk(cause_wdg == m_cw, cur_req, "cause_wdg", cause_wdg, m_cw);
        chk(cause_awake == m_ca, cur_req, "cause_awake", cause_awake, m_ca);
        chk(cause_code == m_cc, cur_req, "cause_code", cause_code, m_cc);
        if (rst_pulse) pulse_seen = 1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_key(logic [1:0] k);
        svc_wr = 1; svc_key = k; cyc(); svc_wr = 0;
    endtask

    task automatic quiesce();
        term_en = 0; stat_rd = 1; cyc(); stat_rd = 0; idle(L + 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cycles, LIMIT);
            finish_run();
        end
    end

    initial begin
        int k, hi;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        chk(rst_pulse == 0, "R1", "rst_pulse", rst_pulse, 0);
        chk({cause_wdg, cause_awake, cause_code} == 3'b000, "R1", "causes",
            {cause_wdg, cause_awake, cause_code}, 0);
        idle(4);

        // R2: expiry timing, R5: pulse length
        cur_req = "R2";
        term_en = 1; src_sel = 1;
        k = 0;
        while (!rst_pulse && k < 200) begin cyc(); k++; end
        chk(k == P * T, "R2", "cycles to expiry", k, P * T);
        chk(cause_wdg == 1, "R2", "cause_wdg", cause_wdg, 1);
        cur_req = "R5";
        hi = 1;
        while (rst_pulse && hi < 50) begin cyc(); if (rst_pulse) hi++; end
        chk(hi == L, "R5", "pulse length", hi, L);
        cur_req = "R11";
        stat_rd = 1; cyc(); stat_rd = 0;
        chk(cause_wdg == 0, "R11", "cause cleared", cause_wdg, 0);
        quiesce();

        // R3: regular servicing prevents reset
        cur_req = "R3";
        term_en = 1; src_sel = 1; pulse_seen = 0;
        for (int i = 0; i < 8; i++) begin idle(20); wr_key(2'b10); wr_key(2'b01); end
        chk(pulse_seen == 0, "R3", "pulse while serviced", pulse_seen, 0);
        quiesce();

        // R4: aborted or out-of-order sequences do not service
        cur_req = "R4";
        term_en = 1; src_sel = 1; pulse_seen = 0;
        for (int i = 0; i < 3; i++) begin
            idle(8); wr_key(2'b10); wr_key(2'b11); wr_key(2'b01); wr_key(2'b01);
        end
        chk(pulse_seen == 1, "R4", "pulse after bad sequences", pulse_seen, 1);
        quiesce();

        // R6: awake falling edge; R10 clk_req
        cur_req = "R6";
        term_en = 1; src_sel = 0; idle(2);
        awake_n = 0; cyc();
        chk(rst_pulse == 1 && cause_awake == 1, "R6", "awake launch", rst_pulse, 1);
        chk(clk_req == 1, "R10", "clk_req low awake", clk_req, 1);
        idle(L + 2); awake_n = 1; idle(2);
        stat_rd = 1; cyc(); stat_rd = 0;

        // R7: code change
        cur_req = "R7";
        code_chg = 1; cyc(); code_chg = 0;
        chk(rst_pulse == 1 && cause_code == 1, "R7", "code launch", cause_code, 1);
        // R5: trigger during pulse ignored
        cur_req = "R5";
        awake_n = 0; cyc(); awake_n = 1;
        chk(cause_awake == 0, "R5", "awake during pulse", cause_awake, 0);
        idle(L + 2);
        // R11: read coincides with new trigger
        cur_req = "R11";
        code_chg = 1; stat_rd = 1; cyc(); code_chg = 0; stat_rd = 0;
        chk(cause_code == 1, "R11", "set wins over read", cause_code, 1);
        idle(L + 2);

        // R8: wake mode never expires; watchdog mode ignores wake events
        cur_req = "R8";
        pulse_seen = 0; idle(3 * P * T);
        chk(pulse_seen == 0, "R8", "no expiry in wake mode", pulse_seen, 0);
        quiesce();
        term_en = 1; src_sel = 1; idle(3);
        awake_n = 0; code_chg = 1; cyc(); code_chg = 0; awake_n = 1; cyc();
        chk(cause_awake == 0 && cause_code == 0, "R8", "wake events in wdg mode",
            {cause_awake, cause_code}, 0);
        quiesce();

        // R9: disabled
        cur_req = "R9";
        term_en = 0; src_sel = 0; pulse_seen = 0;
        awake_n = 0; cyc(); awake_n = 1; code_chg = 1; cyc(); code_chg = 0;
        src_sel = 1; idle(2 * P * T);
        chk(pulse_seen == 0, "R9", "pulse while disabled", pulse_seen, 0);
        chk(clk_req == 0, "R10", "clk_req disabled", clk_req, 0);

        // random mix checked against the model
        cur_req = "R8";
        for (int i = 0; i < 4000; i++) begin
            term_en  = ($urandom_range(0, 15) != 0);
            if ($urandom_range(0, 63) == 0) src_sel = ~src_sel;
            svc_wr   = ($urandom_range(0, 5) == 0);
            svc_key  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3))
                       : (($urandom_range(0, 1) == 0) ? 2'b10 : 2'b01);
            if ($urandom_range(0, 9) == 0) awake_n = ~awake_n;
            code_chg = ($urandom_range(0, 40) == 0);
            stat_rd  = ($urandom_range(0, 12) == 0);
            cyc();
        end
        finish_run();
    end
endmodule